// File: doc/BRIEF.md
# I2C Byte Counter and Receive Holding Logic

This block sits beside the bit-level engine of an I2C controller and owns two pieces of its register set. The first is a 16-bit programmable transfer length. When a transfer begins, the programmed length is copied into a working down counter. Each byte the engine moves on the bus lowers the counter by one. When the counter runs out and stop generation is enabled, the block sends the engine a one-cycle request to put a STOP condition on the bus. A programmed length of zero is taken as the largest possible transfer, 65536 bytes. In repeat mode the length is ignored and the counter never asks for a STOP.

The second piece is the receive side. The engine hands over each received byte with a strobe. The block latches the byte, raises a receive-ready flag and marks a pending receive interrupt. The interrupt vector output shows code 4 for that pending interrupt unless another source with a higher-priority code is active. A bus read of the receive register returns the byte with the upper bits zero. The same read drops the ready flag, and it drops the pending receive interrupt only when code 4 is the code on the vector at that moment.

Top module: `i2c_count_rx`

## Requirements
- R1: Address 0 holds the 16-bit transfer length. It resets to 0, it is written by a bus write to address 0, and a read at address 0 returns it in the same cycle. Addresses other than 0 and 1 read as 0.
- R2: A start pulse loads the working counter from the length register. Each byte-done pulse lowers the counter by one, and no STOP request appears before the final byte of the programmed length.
- R3: When a byte-done pulse takes the counter from 1 to 0 with stop enable at 1 and repeat at 0, `stop_req_o` is high for exactly the following cycle. Further byte-done pulses while the counter is at 0 raise no further request.
- R4: A length of 1 gives a STOP request after one byte. A length of 0 gives a STOP request after 65536 bytes and not before.
- R5: While repeat is 1, byte-done pulses leave the counter unchanged and no STOP request is raised.
- R6: While stop enable is 0, the counter still runs down but no STOP request is raised.
- R7: A receive-valid strobe latches the byte. One cycle later `rx_ready_o` is 1, and a read at address 1 returns the byte in bits 7:0 with bits 15:8 equal to 0.
- R8: A bus write to address 1 changes neither the held byte nor the ready flag.
- R9: A bus read at address 1 clears `rx_ready_o` in the next cycle. If a new byte arrives in the same cycle, the flag stays set and the new byte is held.
- R10: A received byte with receive interrupt enable at 1 makes the receive interrupt pending. The vector shows `other_vec_i` when that input is 1, 2 or 3. Otherwise it shows 4 while the receive interrupt is pending, and `other_vec_i` when it is not. A read at address 1 clears the pending receive interrupt only if the vector shows 4 in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_addr_i | input | 2 | Register select: 0 length, 1 receive data |
| bus_wr_i | input | 1 | Bus write strobe |
| bus_rd_i | input | 1 | Bus read strobe (side effects on address 1) |
| bus_wdata_i | input | 16 | Bus write data |
| bus_rdata_o | output | 16 | Bus read data for the selected address |
| stop_en_i | input | 1 | Stop generation enable from the mode register |
| repeat_i | input | 1 | Repeat mode from the mode register |
| xfer_start_i | input | 1 | Transfer start pulse from the bus engine |
| byte_done_i | input | 1 | One pulse per byte transmitted or received |
| stop_req_o | output | 1 | One-cycle STOP request to the bus engine |
| rx_valid_i | input | 1 | New received byte strobe |
| rx_byte_i | input | 8 | Received byte |
| rx_ie_i | input | 1 | Receive interrupt enable |
| rx_ready_o | output | 1 | Receive-ready flag |
| other_vec_i | input | 4 | Vector code from the other interrupt sources, 0 when none |
| int_vec_o | output | 4 | Resolved interrupt vector code |

## Verification
Read data and the vector output are combinational from the current address and `other_vec_i`, so they are due in the same cycle. `stop_req_o`, `rx_ready_o` and the effect of a read or a new byte on the vector are due one clock edge after the stimulus. Inputs change on falling edges. A behavioural model updates on each rising edge, and every output is compared 1 ns after that edge, once the registered results have settled. The directed checks count STOP pulses over a few idle cycles after the last byte, which covers the one-cycle latency of the request.

// File: rtl/xfc_pkg.sv
package xfc_pkg;

    // register selects decoded on the bus address
    localparam int unsigned XFC_ADDR_LEN    = 0;
    localparam int unsigned XFC_ADDR_RXDATA = 1;

    // vector code of the receive interrupt; lower codes outrank it
    localparam int unsigned XFC_RX_CODE     = 4;

endpackage

// File: rtl/xfc_counter.sv
module xfc_counter
    import xfc_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             len_wr_i,
    input  logic [CNT_W-1:0] len_wdata_i,
    input  logic             start_i,
    input  logic             step_i,
    input  logic             stop_en_i,
    input  logic             repeat_i,
    output logic [CNT_W-1:0] len_o,
    output logic             stop_req_o
);

    // one extra bit so that a programmed zero runs the full 2**CNT_W bytes
    localparam int unsigned WORK_W = CNT_W + 1;

    typedef struct packed {
        logic [CNT_W-1:0]  len;
        logic [WORK_W-1:0] work;
        logic              stop;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.stop = 1'b0;

        if (len_wr_i) begin
            st_d.len = len_wdata_i;
        end

        if (start_i) begin
            if (st_q.len == '0) begin
                st_d.work = {1'b1, {CNT_W{1'b0}}};
            end else begin
                st_d.work = {1'b0, st_q.len};
            end
        end else if (step_i && !repeat_i && (st_q.work != '0)) begin
            st_d.work = st_q.work - WORK_W'(1);
            if ((st_q.work == WORK_W'(1)) && stop_en_i) begin
                st_d.stop = 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign len_o      = st_q.len;
    assign stop_req_o = st_q.stop;

endmodule

// File: rtl/xfc_rx.sv
module xfc_rx
    import xfc_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              new_i,
    input  logic [DATA_W-1:0] byte_i,
    input  logic              ie_i,
    input  logic              rd_i,
    input  logic              shown_i,
    output logic [DATA_W-1:0] data_o,
    output logic              ready_o,
    output logic              pend_o
);

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              ready;
        logic              pend;
    } rx_state_t;

    rx_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;

        // a fresh byte outranks a clearing read in the same cycle
        if (new_i) begin
            st_d.data  = byte_i;
            st_d.ready = 1'b1;
        end else if (rd_i) begin
            st_d.ready = 1'b0;
        end

        if (new_i && ie_i) begin
            st_d.pend = 1'b1;
        end else if (rd_i && shown_i) begin
            st_d.pend = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign data_o  = st_q.data;
    assign ready_o = st_q.ready;
    assign pend_o  = st_q.pend;

endmodule

// File: rtl/xfc_regif.sv
module xfc_regif
    import xfc_pkg::*;
#(
    parameter int unsigned ADDR_W = 2,
    parameter int unsigned BUS_W  = 16,
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned DATA_W = 8,
    parameter int unsigned VEC_W  = 4
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_i,
    input  logic              rd_i,
    input  logic [CNT_W-1:0]  len_i,
    input  logic [DATA_W-1:0] rx_data_i,
    input  logic              rx_pend_i,
    input  logic [VEC_W-1:0]  other_vec_i,
    output logic              len_wr_o,
    output logic              rx_rd_o,
    output logic [BUS_W-1:0]  rdata_o,
    output logic [VEC_W-1:0]  vec_o,
    output logic              rx_shown_o
);

    localparam logic [ADDR_W-1:0] SEL_LEN = ADDR_W'(XFC_ADDR_LEN);
    localparam logic [ADDR_W-1:0] SEL_RX  = ADDR_W'(XFC_ADDR_RXDATA);
    localparam logic [VEC_W-1:0]  CODE_RX = VEC_W'(XFC_RX_CODE);

    typedef struct packed {
        logic              len_wr;
        logic              rx_rd;
        logic [BUS_W-1:0]  rdata;
        logic [VEC_W-1:0]  vec;
        logic              shown;
    } decode_t;

    decode_t dec_d;
    logic    higher_q;

    always_comb begin
        dec_d        = '0;
        dec_d.len_wr = wr_i && (addr_i == SEL_LEN);
        dec_d.rx_rd  = rd_i && (addr_i == SEL_RX);

        unique case (addr_i)
            SEL_LEN: dec_d.rdata = BUS_W'(len_i);
            SEL_RX:  dec_d.rdata = BUS_W'(rx_data_i);
            default: dec_d.rdata = '0;
        endcase

        higher_q = (other_vec_i != '0) && (other_vec_i < CODE_RX);
        if (higher_q) begin
            dec_d.vec = other_vec_i;
        end else if (rx_pend_i) begin
            dec_d.vec   = CODE_RX;
            dec_d.shown = 1'b1;
        end else begin
            dec_d.vec = other_vec_i;
        end
    end

    assign len_wr_o   = dec_d.len_wr;
    assign rx_rd_o    = dec_d.rx_rd;
    assign rdata_o    = dec_d.rdata;
    assign vec_o      = dec_d.vec;
    assign rx_shown_o = dec_d.shown;

endmodule

// File: rtl/i2c_count_rx.sv
module i2c_count_rx
    import xfc_pkg::*;
#(
    parameter int unsigned ADDR_W = 2,
    parameter int unsigned BUS_W  = 16,
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned DATA_W = 8,
    parameter int unsigned VEC_W  = 4
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic              bus_wr_i,
    input  logic              bus_rd_i,
    input  logic [BUS_W-1:0]  bus_wdata_i,
    output logic [BUS_W-1:0]  bus_rdata_o,
    input  logic              stop_en_i,
    input  logic              repeat_i,
    input  logic              xfer_start_i,
    input  logic              byte_done_i,
    output logic              stop_req_o,
    input  logic              rx_valid_i,
    input  logic [DATA_W-1:0] rx_byte_i,
    input  logic              rx_ie_i,
    output logic              rx_ready_o,
    input  logic [VEC_W-1:0]  other_vec_i,
    output logic [VEC_W-1:0]  int_vec_o
);

    logic              len_wr;
    logic              rx_rd;
    logic              rx_shown;
    logic              rx_pend;
    logic [CNT_W-1:0]  len_val;
    logic [DATA_W-1:0] rx_data;

    xfc_regif #(
        .ADDR_W (ADDR_W),
        .BUS_W  (BUS_W),
        .CNT_W  (CNT_W),
        .DATA_W (DATA_W),
        .VEC_W  (VEC_W)
    ) u_regif (
        .addr_i      (bus_addr_i),
        .wr_i        (bus_wr_i),
        .rd_i        (bus_rd_i),
        .len_i       (len_val),
        .rx_data_i   (rx_data),
        .rx_pend_i   (rx_pend),
        .other_vec_i (other_vec_i),
        .len_wr_o    (len_wr),
        .rx_rd_o     (rx_rd),
        .rdata_o     (bus_rdata_o),
        .vec_o       (int_vec_o),
        .rx_shown_o  (rx_shown)
    );

    xfc_counter #(
        .CNT_W (CNT_W)
    ) u_counter (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .len_wr_i    (len_wr),
        .len_wdata_i (bus_wdata_i[CNT_W-1:0]),
        .start_i     (xfer_start_i),
        .step_i      (byte_done_i),
        .stop_en_i   (stop_en_i),
        .repeat_i    (repeat_i),
        .len_o       (len_val),
        .stop_req_o  (stop_req_o)
    );

    xfc_rx #(
        .DATA_W (DATA_W)
    ) u_rx (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .new_i   (rx_valid_i),
        .byte_i  (rx_byte_i),
        .ie_i    (rx_ie_i),
        .rd_i    (rx_rd),
        .shown_i (rx_shown),
        .data_o  (rx_data),
        .ready_o (rx_ready_o),
        .pend_o  (rx_pend)
    );

endmodule

// File: rtl/xfc_chk.sv
module xfc_chk
    import xfc_pkg::*;
#(
    parameter int unsigned ADDR_W = 2,
    parameter int unsigned BUS_W  = 16,
    parameter int unsigned DATA_W = 8,
    parameter int unsigned VEC_W  = 4
) (
    input logic                    clk_i,
    input logic                    rst_ni,
    input logic [ADDR_W-1:0]       bus_addr_i,
    input logic                    bus_rd_i,
    input logic [BUS_W-DATA_W-1:0] rdata_hi_i,
    input logic                    stop_en_i,
    input logic                    repeat_i,
    input logic                    xfer_start_i,
    input logic                    byte_done_i,
    input logic                    stop_req_o,
    input logic                    rx_valid_i,
    input logic                    rx_ready_o,
    input logic [VEC_W-1:0]        int_vec_o
);

    localparam logic [ADDR_W-1:0] SEL_RX  = ADDR_W'(XFC_ADDR_RXDATA);
    localparam logic [VEC_W-1:0]  CODE_RX = VEC_W'(XFC_RX_CODE);

    // R3
    stop_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stop_req_o |=> !stop_req_o);

    // R5
    stop_repeat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stop_req_o |-> $past(!repeat_i));

    // R6
    stop_enable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stop_req_o |-> $past(stop_en_i && byte_done_i && !xfer_start_i));

    // R7
    rx_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rx_valid_i |=> rx_ready_o);

    // R7
    rx_upper_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_addr_i == SEL_RX) |-> (rdata_hi_i == '0));

    // R9
    rx_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_rd_i && (bus_addr_i == SEL_RX) && !rx_valid_i) |=> !rx_ready_o);

    // R10
    vec_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_rd_i && (bus_addr_i == SEL_RX) && (int_vec_o == CODE_RX) && !rx_valid_i)
        |=> (int_vec_o != CODE_RX));

endmodule

bind i2c_count_rx xfc_chk #(
    .ADDR_W (ADDR_W),
    .BUS_W  (BUS_W),
    .DATA_W (DATA_W),
    .VEC_W  (VEC_W)
) i_xfc_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .bus_addr_i   (bus_addr_i),
    .bus_rd_i     (bus_rd_i),
    .rdata_hi_i   (bus_rdata_o[BUS_W-1:DATA_W]),
    .stop_en_i    (stop_en_i),
    .repeat_i     (repeat_i),
    .xfer_start_i (xfer_start_i),
    .byte_done_i  (byte_done_i),
    .stop_req_o   (stop_req_o),
    .rx_valid_i   (rx_valid_i),
    .rx_ready_o   (rx_ready_o),
    .int_vec_o    (int_vec_o)
);

// File: tb/test_i2c_count_rx.sv
`timescale 1ns/1ps
module test_i2c_count_rx;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [15:0] bus_wdata = 16'h0;
    logic [15:0] bus_rdata;
    logic        stop_en = 1'b0;
    logic        rpt = 1'b0;
    logic        xfer_start = 1'b0;
    logic        byte_done = 1'b0;
    logic        stop_req;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_byte = 8'h0;
    logic        rx_ie = 1'b0;
    logic        rx_ready;
    logic [3:0]  other_vec = 4'd0;
    logic [3:0]  int_vec;

    int n_chk = 0;
    int n_fail = 0;
    int stops_seen = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    i2c_count_rx i_i2c_count_rx (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .bus_addr_i   (bus_addr),
        .bus_wr_i     (bus_wr),
        .bus_rd_i     (bus_rd),
        .bus_wdata_i  (bus_wdata),
        .bus_rdata_o  (bus_rdata),
        .stop_en_i    (stop_en),
        .repeat_i     (rpt),
        .xfer_start_i (xfer_start),
        .byte_done_i  (byte_done),
        .stop_req_o   (stop_req),
        .rx_valid_i   (rx_valid),
        .rx_byte_i    (rx_byte),
        .rx_ie_i      (rx_ie),
        .rx_ready_o   (rx_ready),
        .other_vec_i  (other_vec),
        .int_vec_o    (int_vec)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic [15:0] m_len;
    logic [16:0] m_work;
    logic        m_stop;
    logic [7:0]  m_byte;
    logic        m_ready;
    logic        m_pend;

    function automatic logic [3:0] exp_vec(input logic pend, input logic [3:0] other);
        if (other >= 4'd1 && other <= 4'd3) return other;
        if (pend) return 4'd4;
        return other;
    endfunction

    function automatic logic [15:0] exp_rdata(input logic [1:0] a);
        if (a == 2'd0) return m_len;
        if (a == 2'd1) return {8'h00, m_byte};
        return 16'h0;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_len <= 16'h0; m_work <= 17'h0; m_stop <= 1'b0;
            m_byte <= 8'h0; m_ready <= 1'b0; m_pend <= 1'b0;
        end else begin
            m_stop <= 1'b0;
            if (bus_wr && bus_addr == 2'd0) m_len <= bus_wdata;
            if (xfer_start) begin
                m_work <= (m_len == 16'h0) ? 17'h10000 : {1'b0, m_len};
            end else if (byte_done && !rpt && m_work != 17'h0) begin
                m_work <= m_work - 17'h1;
                if (m_work == 17'h1 && stop_en) m_stop <= 1'b1;
            end
            if (rx_valid) begin
                m_byte <= rx_byte; m_ready <= 1'b1;
            end else if (bus_rd && bus_addr == 2'd1) begin
                m_ready <= 1'b0;
            end
            if (rx_valid && rx_ie) m_pend <= 1'b1;
            else if (bus_rd && bus_addr == 2'd1 && exp_vec(m_pend, other_vec) == 4'd4) m_pend <= 1'b0;
        end
    end

    // compare every cycle, 1 ns after the rising edge
    always @(posedge clk) begin
        #1;
        if (rst_n && !done) begin
            chk("R3 stop_req vs model", 32'(stop_req), 32'(m_stop));
            chk("R9 rx_ready vs model", 32'(rx_ready), 32'(m_ready));
            chk("R10 int_vec vs model", 32'(int_vec), 32'(exp_vec(m_pend, other_vec)));
            if (bus_addr == 2'd1) chk("R7 receive read data vs model", 32'(bus_rdata), 32'(exp_rdata(bus_addr)));
            else chk("R1 read data vs model", 32'(bus_rdata), 32'(exp_rdata(bus_addr)));
        end
    end

    always @(posedge clk) if (rst_n && stop_req) stops_seen++;

    // ---------------- stimulus helpers ----------------
    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk); bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic start_xfer();
        @(negedge clk); xfer_start = 1'b1;
        @(negedge clk); xfer_start = 1'b0;
    endtask

    task automatic send_bytes(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); byte_done = 1'b1;
        end
        @(negedge clk); byte_done = 1'b0;
    endtask

    task automatic run_len(input logic [15:0] len, input int total, input string tag);
        int base;
        bus_write(2'd0, len);
        start_xfer();
        base = stops_seen;
        send_bytes(total - 1);
        idle(3);
        chk({"R2 no stop before last byte ", tag}, 32'(stops_seen - base), 32'd0);
        send_bytes(1);
        idle(3);
        chk({"R4 one stop after last byte ", tag}, 32'(stops_seen - base), 32'd1);
        send_bytes(4);
        idle(3);
        chk({"R3 no repeat stop at zero ", tag}, 32'(stops_seen - base), 32'd1);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    // ---------------- main sequence ----------------
    initial begin
        int base;
        logic [3:0] vec_set [6] = '{4'd0, 4'd1, 4'd2, 4'd3, 4'd5, 4'd6};
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 length register resets to 0", 32'(bus_rdata), 32'h0);
        chk("R9 ready clear after reset", 32'(rx_ready), 32'h0);

        bus_write(2'd0, 16'hBEEF);
        chk("R1 length readback", 32'(bus_rdata), 32'hBEEF);
        bus_addr = 2'd2;
        #1 chk("R1 unused address reads 0", 32'(bus_rdata), 32'h0);

        stop_en = 1'b1;
        run_len(16'd1, 1, "len 1");
        run_len(16'd37, 37, "len 37");
        run_len(16'd0, 65536, "len 0");

        // repeat mode suppresses the stop
        rpt = 1'b1;
        bus_write(2'd0, 16'd3);
        start_xfer();
        base = stops_seen;
        send_bytes(6);
        idle(3);
        chk("R5 repeat mode gives no stop", 32'(stops_seen - base), 32'd0);
        rpt = 1'b0;

        // stop enable off
        stop_en = 1'b0;
        bus_write(2'd0, 16'd2);
        start_xfer();
        base = stops_seen;
        send_bytes(3);
        idle(3);
        chk("R6 stop disabled gives no stop", 32'(stops_seen - base), 32'd0);
        stop_en = 1'b1;

        // receive path
        @(negedge clk); rx_ie = 1'b1; rx_valid = 1'b1; rx_byte = 8'hA5; bus_addr = 2'd1;
        @(negedge clk); rx_valid = 1'b0;
        chk("R7 ready after byte", 32'(rx_ready), 32'd1);
        chk("R7 receive read data", 32'(bus_rdata), 32'h00A5);
        chk("R10 vector shows receive", 32'(int_vec), 32'd4);

        bus_write(2'd1, 16'hFFFF);
        chk("R8 write to receive reg ignored", 32'(bus_rdata), 32'h00A5);
        chk("R8 ready kept after write", 32'(rx_ready), 32'd1);

        @(negedge clk); bus_rd = 1'b1;
        @(negedge clk); bus_rd = 1'b0;
        chk("R9 read clears ready", 32'(rx_ready), 32'd0);
        chk("R10 read clears vector 4", 32'(int_vec), 32'd0);

        @(negedge clk); rx_valid = 1'b1; rx_byte = 8'h3C; bus_rd = 1'b1;
        @(negedge clk); rx_valid = 1'b0; bus_rd = 1'b0;
        chk("R9 new byte wins over read", 32'(rx_ready), 32'd1);
        chk("R7 new byte held", 32'(bus_rdata), 32'h003C);

        @(negedge clk); other_vec = 4'd2;
        #1 chk("R10 higher code outranks receive", 32'(int_vec), 32'd2);
        @(negedge clk); bus_rd = 1'b1;
        @(negedge clk); bus_rd = 1'b0;
        chk("R9 read clears ready under higher code", 32'(rx_ready), 32'd0);
        other_vec = 4'd0;
        #1 chk("R10 receive still pending after masked read", 32'(int_vec), 32'd4);
        @(negedge clk); bus_rd = 1'b1;
        @(negedge clk); bus_rd = 1'b0;
        chk("R10 second read clears vector 4", 32'(int_vec), 32'd0);

        @(negedge clk); rx_ie = 1'b0; rx_valid = 1'b1; rx_byte = 8'h11;
        @(negedge clk); rx_valid = 1'b0;
        chk("R10 disabled interrupt not pending", 32'(int_vec), 32'd0);

        // mixed traffic against the model
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            xfer_start = ($urandom % 40) == 0;
            byte_done  = ($urandom % 3) == 0;
            bus_addr   = 2'($urandom % 3);
            bus_rd     = ($urandom % 4) == 0;
            bus_wr     = ($urandom % 15) == 0;
            bus_wdata  = 16'($urandom % 6);
            rx_valid   = ($urandom % 5) == 0;
            rx_byte    = 8'($urandom);
            rx_ie      = ($urandom % 4) != 0;
            other_vec  = vec_set[$urandom % 6];
            if ($urandom % 50 == 0) stop_en = ~stop_en;
            if ($urandom % 60 == 0) rpt = ~rpt;
        end
        @(negedge clk);
        xfer_start = 1'b0; byte_done = 1'b0; bus_rd = 1'b0; bus_wr = 1'b0;
        rx_valid = 1'b0; other_vec = 4'd0;
        idle(3);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule